// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator

This block gathers interrupt requests from ten on-chip sources into a single status register. It produces one interrupt line toward the host processor. Every source level is captured once per clock. The captured vector is then filtered by six group-enable bits and reduced to one combined request.

A small control register shapes how that combined request reaches the host. One bit is a master gate that can force the line low. A second bit chooses the signalling mode. In level mode the line stays high while any enabled source is pending. In pulse mode the line gives a single-cycle pulse each time the combined request goes from 0 to 1.

Software writes the control register through a write strobe and data bus. It reads back the control value and the raw source status on dedicated outputs.

Top module: `irq_agg`

## Requirements
- R1: After reset, the control readback, the status readback and the host interrupt line are all 0.
- R2: When `ctrlWrEn` is high at a rising clock edge, `ctrlWrData` is stored and appears on `ctrlRd` after that edge.
- R3: `statusRd` shows the raw source levels captured at the previous clock edge, whatever the control value is. The bit order is: bits 0 to 3 are the four general-purpose I/O banks, bits 4 to 6 are the three LED channels, bit 7 is the serial peripheral, bit 8 is the SMBus controller and bit 9 is the one-wire controller.
- R4: Control bits 2 to 7 are group enables, where 1 lets the group through. Control bit 2 admits source 0, bit 3 admits source 1, bit 4 admits source 2 and bit 5 admits source 3. Bit 6 admits sources 4 to 6 together. Bit 7 admits sources 7 to 9 together.
- R5: A source whose group enable is 0 never causes the host line to go high.
- R6: While control bit 0 (master gate) is 0, the host line is 0.
- R7: In level mode (control bit 1 = 0) with the gate on, the host line is high in exactly the cycles in which the captured status has at least one enabled source set.
- R8: In pulse mode (control bit 1 = 1) with the gate on, the host line is high for one cycle after each 0-to-1 change of the combined request. It stays low while the request remains high.
- R9: In pulse mode, a rise of the combined request caused by a control write (unmasking a pending source) produces a pulse, just like a rise caused by a source.
- R10: In pulse mode, after the combined request falls back to 0, a new rise produces a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 8 | Control register write value |
| srcReq | input | 10 | Raw request levels from the sources |
| ctrlRd | output | 8 | Control register readback |
| statusRd | output | 10 | Captured source status readback |
| hostIrq | output | 1 | Interrupt line to the host |

## Verification
A control write and a change in source level can land on the same clock edge. The combined request then moves because of both. The bench provokes this case in several ways: it unmasks a group in the same cycle that its source rises; it masks a group while the source falls; and it flips the mode while the request is held high. The expected line value is computed from a model in which the new control value and the new status both take effect at that edge. For pulse mode, the model holds exactly one previous-cycle combined request, so a rise caused jointly by both changes yields exactly one pulse.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int NUM_SRC  = 10;
  localparam int NUM_GRP  = 6;
  localparam int CTRL_W   = 2 + NUM_GRP;
  localparam int GPIO_GRP = 4;
  localparam int LED_LAST = 6;

  typedef struct packed {
    logic [NUM_GRP-1:0] grpEn;
    logic               edgeMode;
    logic               globalEn;
  } irqCtrlT;

  // Group index owning a source position.
  function automatic int grpOf(input int src);
    if (src < GPIO_GRP) return src;
    else if (src <= LED_LAST) return GPIO_GRP;
    else return GPIO_GRP + 1;
  endfunction

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  output logic [CTRL_W-1:0] ctrlQ,
  output irqCtrlT           ctrlOut
);

  always_ff @(posedge clk) begin
    if (!rstN)     ctrlQ <= '0;
    else if (wrEn) ctrlQ <= wrData;
  end

  assign ctrlOut = irqCtrlT'(ctrlQ);

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ctrlQ == $past(wrData));

  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(ctrlQ));

endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  irqCtrlT            ctrlIn,
  output logic [NUM_SRC-1:0] statusQ,
  output logic               hostIrq
);

  logic [NUM_SRC-1:0] srcPass;
  logic               combReq;
  logic               combPrev;
  logic               riseSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ  <= '0;
      combPrev <= 1'b0;
    end else begin
      statusQ  <= srcReq;
      combPrev <= combReq;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pass
    assign srcPass[i] = statusQ[i] & ctrlIn.grpEn[grpOf(i)];
  end

  assign combReq  = |srcPass;
  assign riseSeen = combReq & ~combPrev;

  always_comb begin
    if (!ctrlIn.globalEn)     hostIrq = 1'b0;
    else if (ctrlIn.edgeMode) hostIrq = riseSeen;
    else                      hostIrq = combReq;
  end

  assert_status_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> statusQ == $past(srcReq));

  assert_gate_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlIn.globalEn |-> !hostIrq);

  assert_needs_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> statusQ != '0);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostIrq && ctrlIn.edgeMode) |=> !(hostIrq && ctrlIn.edgeMode));

endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlWrEn,
  input  logic [CTRL_W-1:0]  ctrlWrData,
  input  logic [NUM_SRC-1:0] srcReq,
  output logic [CTRL_W-1:0]  ctrlRd,
  output logic [NUM_SRC-1:0] statusRd,
  output logic               hostIrq
);

  irqCtrlT ctrlBus;

  irq_agg_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (ctrlWrEn),
    .wrData (ctrlWrData),
    .ctrlQ  (ctrlRd),
    .ctrlOut(ctrlBus)
  );

  irq_agg_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .srcReq (srcReq),
    .ctrlIn (ctrlBus),
    .statusQ(statusRd),
    .hostIrq(hostIrq)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (ctrlRd == '0 && statusRd == '0 && !hostIrq));

endmodule

// File: tb/tb_irq_agg.sv
`timescale 1ns/1ps
module tb_irq_agg;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWrEn = 1'b0;
  logic [7:0] ctrlWrData = '0;
  logic [9:0] srcReq = '0;
  logic [7:0] ctrlRd;
  logic [9:0] statusRd;
  logic       hostIrq;

  int  testCnt = 0;
  int  failCnt = 0;
  bit  done = 1'b0;

  logic [7:0] mCtrl = '0;
  logic [9:0] mStat = '0;
  logic       mPrev = 1'b0;

  always #2 clk = ~clk;

  irq_agg dut (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .srcReq(srcReq), .ctrlRd(ctrlRd), .statusRd(statusRd), .hostIrq(hostIrq)
  );

  function automatic logic modelComb(input logic [9:0] s, input logic [7:0] c);
    logic r = 1'b0;
    for (int i = 0; i < 10; i++) begin
      int g;
      g = (i < 4) ? i : ((i < 7) ? 4 : 5);
      if (s[i] && c[2+g]) r = 1'b1;
    end
    return r;
  endfunction

  task automatic checkVal(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One clock: drive at negedge, update model at the edge, sample after it.
  task automatic step(input logic [9:0] s, input logic w, input logic [7:0] d,
                      input string req);
    logic comb;
    logic expIrq;
    @(negedge clk);
    srcReq = s; ctrlWrEn = w; ctrlWrData = d;
    @(posedge clk);
    #1;
    if (w) mCtrl = d;
    mStat = s;
    comb = modelComb(mStat, mCtrl);
    if (!mCtrl[0])     expIrq = 1'b0;
    else if (mCtrl[1]) expIrq = comb & ~mPrev;
    else               expIrq = comb;
    mPrev = comb;
    checkVal(req, "hostIrq", {31'b0, hostIrq}, {31'b0, expIrq});
    checkVal("R3", "statusRd", {22'b0, statusRd}, {22'b0, mStat});
    checkVal("R2", "ctrlRd", {24'b0, ctrlRd}, {24'b0, mCtrl});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    checkVal("R1", "ctrlRd", {24'b0, ctrlRd}, 32'h0);
    checkVal("R1", "statusRd", {22'b0, statusRd}, 32'h0);
    checkVal("R1", "hostIrq", {31'b0, hostIrq}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R4 R5 R7: level mode, every mask against single sources, none and all
    for (int m = 0; m < 64; m++) begin
      step('0, 1'b1, {m[5:0], 2'b01}, "R4");
      for (int i = 0; i < 10; i++) step(10'(1 << i), 1'b0, 8'h0, "R7");
      step(10'h3ff, 1'b0, 8'h0, "R7");
      step(10'h000, 1'b0, 8'h0, "R5");
    end

    // R6: master gate off, all masks open, all sources
    step('0, 1'b1, 8'hfc, "R6");
    step(10'h3ff, 1'b0, 8'h0, "R6");
    step(10'h155, 1'b0, 8'h0, "R6");
    step(10'h3ff, 1'b1, 8'hfe, "R6");

    // R8 R10: pulse mode, each mask against each source, rise/hold/fall/rise
    for (int m = 0; m < 64; m++) begin
      step('0, 1'b1, {m[5:0], 2'b11}, "R8");
      for (int i = 0; i < 10; i++) begin
        step(10'(1 << i), 1'b0, 8'h0, "R8");
        step(10'(1 << i), 1'b0, 8'h0, "R8");
        step('0, 1'b0, 8'h0, "R10");
        step(10'(1 << i), 1'b0, 8'h0, "R10");
        step('0, 1'b0, 8'h0, "R10");
      end
    end

    // R9: unmask a pending source in pulse mode
    step('0, 1'b1, 8'h03, "R9");
    step(10'h080, 1'b0, 8'h0, "R9");
    step(10'h080, 1'b1, 8'h83, "R9");
    step(10'h080, 1'b0, 8'h0, "R9");
    // R9: unmask and source rise in the same edge
    step('0, 1'b1, 8'h03, "R9");
    step(10'h020, 1'b1, 8'h43, "R9");
    step(10'h020, 1'b0, 8'h0, "R9");
    // mask while source falls, then a fresh rise
    step(10'h000, 1'b1, 8'h03, "R10");
    step(10'h010, 1'b1, 8'h43, "R10");
    // mode flip while request held
    step(10'h010, 1'b1, 8'h41, "R7");
    step(10'h010, 1'b1, 8'h43, "R8");
    step(10'h010, 1'b0, 8'h0, "R8");
    // enable turned on in pulse mode while request already high: no new rise
    step(10'h010, 1'b1, 8'h42, "R6");
    step(10'h010, 1'b1, 8'h43, "R8");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule